// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches up to sixteen page mappings and converts 32-bit virtual addresses into physical addresses. A virtual address is split into a 20-bit virtual page number and a 12-bit byte offset inside a 4 KB page. Every stored tag is compared with the page number at the same time, so any mapping may sit in any slot. A successful translation joins the stored frame number to the untouched offset.

A lookup that finds no stored mapping is reported as a miss. The surrounding logic then reads the page table in memory and writes the entry back through the refill port. The refill port chooses its slot with a round-robin pointer. A matching mapping that is marked not present raises a page-fault outcome instead of a hit. Each slot keeps a use flag and a modified flag. Hardware sets these flags, and they are exported as vectors so that a replacement policy can read them. Maintenance inputs clear all use flags at once, clear the modified flag of one slot, drop one mapping by page number, or drop every mapping.

Top module: `tlb_xlate`

## Requirements
- R1: Any page number can be stored in any of the 16 slots. A lookup hits when a valid slot's tag equals `lk_vaddr[31:12]` and that slot is marked present.
- R2: On a hit, `rsp_paddr` equals the slot's frame number in bits 31:12 joined with `lk_vaddr[11:0]` in bits 11:0. On a miss, a fault or an idle cycle it is zero.
- R3: Results are registered. `rsp_valid` is high exactly in the cycle after `lk_en` was high. In that cycle exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high, and all three are low when `rsp_valid` is low. After reset all outputs and all flag vectors are zero, and `fill_slot` is 0.
- R4: A lookup for which no valid slot has a matching tag reports `rsp_miss`.
- R5: A lookup whose matching slot is marked not present reports `rsp_fault`. The use and modified flags of that slot do not change.
- R6: A hit sets bit i of `ref_bits` for the slot i that translated it, visible in the cycle after the lookup.
- R7: A hit with `lk_store` high also sets bit i of `dirty_bits`, updated at the same edge as the lookup.
- R8: `fill_en` writes tag, frame and present flag into slot `fill_slot`, sets its valid bit and clears its use and modified flags. `fill_slot` then advances by one and wraps from 15 to 0. A lookup in the same cycle as the refill sees the old contents.
- R9: `clr_ref_all` clears every bit of `ref_bits` in one cycle. A hit in that same cycle still sets its own bit.
- R10: `clr_dirty_en` clears bit `clr_dirty_idx` of `dirty_bits`. A store hit on that slot in the same cycle leaves the bit set.
- R11: `inv_all` clears every bit of `valid_bits`, and this takes precedence over a refill in the same cycle.
- R12: `inv_one` clears the valid bit of the slot whose stored tag equals `inv_vpn`. A refill written into that same slot in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | Lookup is for a write access |
| rsp_valid | output | 1 | Registered result present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No stored mapping matched |
| rsp_fault | output | 1 | Mapping matched but page not present |
| rsp_paddr | output | 32 | Translated physical address |
| fill_en | input | 1 | Write an entry |
| fill_vpn | input | 20 | Page number of the new entry |
| fill_pfn | input | 20 | Frame number of the new entry |
| fill_present | input | 1 | Page of the new entry is resident |
| fill_slot | output | 4 | Slot the next refill will use |
| inv_all | input | 1 | Drop every mapping |
| inv_one | input | 1 | Drop the mapping for inv_vpn |
| inv_vpn | input | 20 | Page number to drop |
| clr_ref_all | input | 1 | Clear every use flag |
| clr_dirty_en | input | 1 | Clear one modified flag |
| clr_dirty_idx | input | 4 | Slot whose modified flag is cleared |
| ref_bits | output | 16 | Use flag per slot |
| dirty_bits | output | 16 | Modified flag per slot |
| valid_bits | output | 16 | Valid flag per slot |

## Verification
The checker assumes that software never holds the same page number in two valid slots, so at most one slot matches a lookup. The bench keeps to this by issuing a refill only for a page number that its reference model shows as absent from every valid slot. Invalidates only ever remove mappings, so they cannot create a duplicate. The checker also assumes that inputs are quiet while reset is held, and the bench drives them low during reset.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;
  typedef enum logic [1:0] {
    XL_NONE  = 2'd0,
    XL_HIT   = 2'd1,
    XL_MISS  = 2'd2,
    XL_FAULT = 2'd3
  } xl_outcome_e;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 20
) (
  input  logic [ENTRIES-1:0]       valid,
  input  logic [ENTRIES*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]         key,
  output logic [ENTRIES-1:0]       match
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valid[i] && (tags[i*TAG_W +: TAG_W] == key);
  end
endmodule

// File: rtl/tlb_oh_enc.sv
module tlb_oh_enc #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     oh,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (oh[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFS_W   = 12,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PFN_W  = PA_W - OFS_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_en,
  input  logic [VA_W-1:0]    lk_vaddr,
  input  logic               lk_store,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic               rsp_fault,
  output logic [PA_W-1:0]    rsp_paddr,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic               fill_present,
  output logic [IDX_W-1:0]   fill_slot,
  input  logic               inv_all,
  input  logic               inv_one,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic               clr_ref_all,
  input  logic               clr_dirty_en,
  input  logic [IDX_W-1:0]   clr_dirty_idx,
  output logic [ENTRIES-1:0] ref_bits,
  output logic [ENTRIES-1:0] dirty_bits,
  output logic [ENTRIES-1:0] valid_bits
);

  // Slot storage: tags and frames carry no reset, flags do
  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [PFN_W-1:0] pfn_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, pres_q, ref_q, dirty_q;
  logic [ENTRIES-1:0] valid_d, pres_d, ref_d, dirty_d;
  logic [ENTRIES*VPN_W-1:0] tags_flat;

  logic [VPN_W-1:0]   lk_vpn;
  logic [OFS_W-1:0]   lk_ofs;
  logic [ENTRIES-1:0] lk_raw, lk_match, hit_vec, inv_raw, inv_match;
  logic [IDX_W-1:0]   sel_idx;
  xl_outcome_e        outcome;

  assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];
  assign lk_ofs = lk_vaddr[OFS_W-1:0];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_flat
    assign tags_flat[i*VPN_W +: VPN_W] = tag_q[i];
  end

  tlb_cam_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_lk_cam (
    .valid(valid_q), .tags(tags_flat), .key(lk_vpn), .match(lk_raw)
  );

  tlb_cam_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_inv_cam (
    .valid(valid_q), .tags(tags_flat), .key(inv_vpn), .match(inv_raw)
  );

  assign lk_match  = lk_raw & {ENTRIES{lk_en}};
  assign hit_vec   = lk_match & pres_q;
  assign inv_match = inv_raw & {ENTRIES{inv_one}};

  tlb_oh_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc (
    .oh(lk_match), .idx(sel_idx)
  );

  tlb_rr_ptr #(.N(ENTRIES), .IDX_W(IDX_W)) u_rr (
    .clk(clk), .rst(rst), .adv(fill_en), .ptr(fill_slot)
  );

  always_comb begin
    if (!lk_en)          outcome = XL_NONE;
    else if (|hit_vec)   outcome = XL_HIT;
    else if (|lk_match)  outcome = XL_FAULT;
    else                 outcome = XL_MISS;
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= (outcome != XL_NONE);
      rsp_hit   <= (outcome == XL_HIT);
      rsp_miss  <= (outcome == XL_MISS);
      rsp_fault <= (outcome == XL_FAULT);
      rsp_paddr <= (outcome == XL_HIT) ? {pfn_q[sel_idx], lk_ofs} : '0;
    end
  end

  // Per-slot flag update: clear, then set by use, then refill, then invalidate-all
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic fill_here, dclr_here;
    assign fill_here = fill_en && (fill_slot == IDX_W'(i));
    assign dclr_here = clr_dirty_en && (clr_dirty_idx == IDX_W'(i));
    assign ref_d[i]   = !fill_here && (hit_vec[i] || (ref_q[i] && !clr_ref_all));
    assign dirty_d[i] = !fill_here && ((hit_vec[i] && lk_store) || (dirty_q[i] && !dclr_here));
    assign pres_d[i]  = fill_here ? fill_present : pres_q[i];
    assign valid_d[i] = !inv_all && (fill_here || (valid_q[i] && !inv_match[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      pres_q  <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      pres_q  <= pres_d;
      ref_q   <= ref_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_slot] <= fill_vpn;
      pfn_q[fill_slot] <= fill_pfn;
    end
  end

  assign ref_bits   = ref_q;
  assign dirty_bits = dirty_q;
  assign valid_bits = valid_q;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int ENTRIES = 16,
  parameter int PA_W    = 32,
  parameter int OFS_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_en,
  input logic [OFS_W-1:0]   lk_ofs,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic               fill_en,
  input logic [IDX_W-1:0]   fill_slot,
  input logic               inv_all,
  input logic               clr_ref_all,
  input logic [ENTRIES-1:0] ref_bits,
  input logic [ENTRIES-1:0] valid_bits,
  input logic [ENTRIES-1:0] lk_match
);

  // Input assumption: no page number is held in two valid slots
  assert_unique_tag_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rsp_valid == $past(lk_en)));

  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rsp_hit) |-> (rsp_paddr[OFS_W-1:0] == $past(lk_ofs)));

  assert_zero_addr_R2: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_paddr == '0));

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (fill_slot == ((($past(fill_slot)) == IDX_W'(ENTRIES - 1)) ? '0 : $past(fill_slot) + 1'b1)));

  assert_clear_ref_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_ref_all && !lk_en) |=> (ref_bits == '0));

  assert_drop_all_R11: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (valid_bits == '0));

endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        lk_en = 0, lk_store = 0;
  logic [31:0] lk_vaddr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        fill_en = 0, fill_present = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [3:0]  fill_slot;
  logic        inv_all = 0, inv_one = 0, clr_ref_all = 0, clr_dirty_en = 0;
  logic [19:0] inv_vpn = '0;
  logic [3:0]  clr_dirty_idx = '0;
  logic [N-1:0] ref_bits, dirty_bits, valid_bits;

  tlb_xlate dut (.*);

  int checks = 0;
  int errors = 0;
  string phase = "R3 reset";

  // Reference model state
  bit m_v[N], m_p[N], m_r[N], m_d[N];
  int m_t[N], m_f[N];
  int m_ptr = 0;
  bit e_v, e_h, e_m, e_f;
  logic [31:0] e_pa;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL [%s] %s actual=%h expected=%h", phase, tag, act, exp);
    end
  endtask

  task automatic clear_stim();
    lk_en = 0; lk_store = 0; lk_vaddr = '0;
    fill_en = 0; fill_vpn = '0; fill_pfn = '0; fill_present = 0;
    inv_all = 0; inv_one = 0; inv_vpn = '0;
    clr_ref_all = 0; clr_dirty_en = 0; clr_dirty_idx = '0;
  endtask

  function automatic bit model_has(input int vpn);
    for (int i = 0; i < N; i++) if (m_v[i] && m_t[i] == vpn) return 1;
    return 0;
  endfunction

  // Called at a falling edge with stimulus already driven
  task automatic step();
    int mi = -1;
    int lvpn = int'(lk_vaddr[31:12]);
    bit hit = 0;
    logic [N-1:0] xr, xd, xv;
    for (int i = 0; i < N; i++) if (m_v[i] && m_t[i] == lvpn) mi = i;
    e_v = lk_en; e_h = 0; e_m = 0; e_f = 0; e_pa = '0;
    if (lk_en) begin
      if (mi < 0) e_m = 1;
      else if (m_p[mi]) begin
        e_h = 1; hit = 1;
        e_pa = {m_f[mi][19:0], lk_vaddr[11:0]};
      end else e_f = 1;
    end
    for (int i = 0; i < N; i++) begin
      if (clr_ref_all) m_r[i] = 0;
      if (clr_dirty_en && int'(clr_dirty_idx) == i) m_d[i] = 0;
      if (hit && mi == i) begin
        m_r[i] = 1;
        if (lk_store) m_d[i] = 1;
      end
      if (inv_one && m_v[i] && m_t[i] == int'(inv_vpn)) m_v[i] = 0;
      if (fill_en && m_ptr == i) begin
        m_t[i] = int'(fill_vpn); m_f[i] = int'(fill_pfn); m_p[i] = fill_present;
        m_v[i] = 1; m_r[i] = 0; m_d[i] = 0;
      end
      if (inv_all) m_v[i] = 0;
    end
    if (fill_en) m_ptr = (m_ptr + 1) % N;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      xr[i] = m_r[i]; xd[i] = m_d[i]; xv[i] = m_v[i];
    end
    chk({rsp_valid, rsp_hit, rsp_miss, rsp_fault} == {e_v, e_h, e_m, e_f},
        e_h ? "R1 hit" : e_m ? "R4 miss" : e_f ? "R5 fault" : "R3 idle",
        {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, {28'd0, e_v, e_h, e_m, e_f});
    chk(rsp_paddr == e_pa, "R2 paddr", rsp_paddr, e_pa);
    chk(ref_bits == xr, "R6 ref_bits", {16'd0, ref_bits}, {16'd0, xr});
    chk(dirty_bits == xd, "R7 dirty_bits", {16'd0, dirty_bits}, {16'd0, xd});
    chk(valid_bits == xv, "R8 valid_bits", {16'd0, valid_bits}, {16'd0, xv});
    chk(int'(fill_slot) == m_ptr, "R8 fill_slot", {28'd0, fill_slot}, 32'(m_ptr));
    clear_stim();
  endtask

  task automatic look(input int vpn, input int ofs, input bit st);
    lk_en = 1; lk_vaddr = {20'(vpn), 12'(ofs)}; lk_store = st;
  endtask

  task automatic fill(input int vpn, input int pfn, input bit pr);
    fill_en = 1; fill_vpn = 20'(vpn); fill_pfn = 20'(pfn); fill_present = pr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL [watchdog] run did not finish actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_p[i] = 0; m_r[i] = 0; m_d[i] = 0; m_t[i] = 0; m_f[i] = 0;
    end
    clear_stim();
    repeat (4) @(negedge clk);
    rst = 0;
    step();  // R3 reset state

    phase = "R8 refill same-cycle lookup";
    fill(32'h12345, 32'hABCDE, 1); look(32'h12345, 32'h678, 0); step();
    phase = "R1 R2 R6 hit after refill";
    look(32'h12345, 32'h678, 0); step();
    phase = "R5 not-present fault";
    fill(32'h00777, 32'h11111, 0); step();
    look(32'h00777, 32'h001, 1); step();
    phase = "R7 store hit";
    look(32'h12345, 32'hFFF, 1); step();
    phase = "R4 miss";
    look(32'h55555, 32'h000, 0); step();
    phase = "R9 clear-reference";
    clr_ref_all = 1; step();
    look(32'h12345, 32'h010, 0); clr_ref_all = 1; step();
    phase = "R10 clear-dirty";
    clr_dirty_en = 1; clr_dirty_idx = 4'd0; step();
    look(32'h12345, 32'h020, 1); step();
    clr_dirty_en = 1; clr_dirty_idx = 4'd0; look(32'h12345, 32'h030, 1); step();
    phase = "R12 single invalidate";
    inv_one = 1; inv_vpn = 20'h12345; step();
    look(32'h12345, 32'h040, 0); step();
    phase = "R8 pointer wrap";
    for (int k = 0; k < 17; k++) begin
      fill(32'h00100 + k, 32'h20000 + k, 1); step();
    end
    look(32'h00110, 32'h5A5, 0); step();
    look(32'h00101, 32'h5A5, 0); step();
    phase = "R11 invalidate all";
    inv_all = 1; fill(32'h0BEEF, 32'h0CAFE, 1); step();
    look(32'h0BEEF, 32'h000, 0); step();

    phase = "R1-random";
    for (int c = 0; c < 3000; c++) begin
      int r = $urandom % 64;
      if ($urandom % 4 != 0) look(32'h40000 + ($urandom % 24), $urandom % 4096, $urandom % 2);
      if (r < 14) begin
        int v = 32'h40000 + ($urandom % 24);
        if (!model_has(v)) fill(v, $urandom % 1048576, ($urandom % 5) != 0);
      end
      if (r >= 14 && r < 18) clr_ref_all = 1;
      if (r >= 18 && r < 26) begin clr_dirty_en = 1; clr_dirty_idx = 4'($urandom % 16); end
      if (r >= 26 && r < 30) begin inv_one = 1; inv_vpn = 20'(32'h40000 + ($urandom % 24)); end
      if (r == 63) inv_all = 1;
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule